// File: doc/BRIEF.md
# Pattern Search Coefficient Tuner

This block tunes six signed fixed-point coefficients by a deterministic pattern search that needs no derivatives. It does not compute the cost itself. Each candidate vector goes out on a request line and stays there until an external evaluator returns a 32-bit unsigned cost for it. A start pulse loads the initial vector. The block then repeats two kinds of move. An exploratory move probes one coordinate at a time. A pattern move extrapolates along the last direction that improved the cost. Every probe uses a single shared step, which is halved when exploration around the base point fails.

Coefficients are Q8.24: 32 bits, two's complement, 24 fraction bits. No bounds are applied, so arithmetic wraps at the word width. The search ends in one of two ways: halving the step would take it below one millionth, or the number of pattern moves reaches the iteration limit. At the end a one-cycle done pulse is raised. The best vector, its cost and the pattern-move count stay on the outputs until the next start.

Top module: `hj_search`

## Requirements
- R1: A start pulse loads `init_coef` as the base point and clears the iteration count. The first request after start presents that vector unchanged, so that its cost can be measured.
- R2: While `ev_req` is high and `ev_valid` is low, `ev_req` stays high on the next cycle and `ev_coef` is unchanged.
- R3: The initial step is 0.1, which is 1677722 LSB in Q8.24. An exploratory move visits coordinates 0 to 5 in order. For each coordinate it first requests the point plus the step, then the point minus the step. A probe is kept only if its cost is strictly lower than the running cost.
- R4: An exploration result is accepted as the new base only if its cost is strictly lower than the base cost. `best_cost` therefore strictly decreases at each acceptance.
- R5: On acceptance the next trial point is twice the new base minus the old base, per coordinate and wrapping at 32 bits. `iter_count` increments by one for each such pattern move, and never by more than one per cycle.
- R6: When exploration around the base fails, the step is arithmetically shifted right by one. The search terminates instead if the halved step would fall below 17 LSB, the nearest Q8.24 value to 1e-6.
- R7: The search terminates when `iter_count` reaches MAX_ITER, which is 1000 by default. The base just accepted is reported.
- R8: `done` is high for exactly one cycle, and never together with `ev_req`. After it, `best_coef` and `best_cost` hold until the next start, and no request is issued.
- R9: The same initial vector and the same cost responses always give the same result.
- R10: After a pattern move, exploration runs around the trial point. If that exploration does not beat the base cost, exploration restarts around the base with the step unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that loads the initial vector and begins a search |
| init_coef | input | 192 | Initial vector, coordinate i in bits [32i+31:32i], Q8.24 |
| ev_req | output | 1 | A candidate awaits its cost |
| ev_coef | output | 192 | Candidate vector, same layout as `init_coef` |
| ev_valid | input | 1 | One-cycle strobe: `ev_cost` belongs to the pending candidate |
| ev_cost | input | 32 | Unsigned cost of the pending candidate |
| done | output | 1 | One-cycle pulse at termination |
| best_coef | output | 192 | Best vector so far, same layout as `init_coef` |
| best_cost | output | 32 | Cost of `best_coef` |
| iter_count | output | 10 | Number of pattern moves in the current search |

## Verification
The assertions assume that `ev_valid` is only strobed while `ev_req` is high. They also assume that each strobe answers the candidate that was present on the request cycles before it. They further assume that `start` is not pulsed while a cost is in flight. The bench evaluator meets these assumptions. It latches the candidate when a request appears, answers once after a fixed latency, and then stays quiet for one cycle so that the next candidate can settle. Starts are issued only after `done`. The cost is an L1 distance to a target that stays well inside the Q8.24 range, so pattern moves never wrap.

// File: rtl/hj_pkg.sv
package hj_pkg;
  localparam int CW = 32;
  localparam int KW = 32;

  typedef logic signed [CW-1:0] coef_t;
  typedef logic [KW-1:0] cost_t;

  typedef enum logic [2:0] {
    S_IDLE, S_BASE, S_PLUS, S_MINUS, S_END, S_PAT, S_FIN
  } st_t;

  // probe one coordinate by +step or -step
  function automatic coef_t probe(coef_t x, coef_t step, logic neg);
    return neg ? coef_t'(x - step) : coef_t'(x + step);
  endfunction

  // extrapolate through the new point away from the old one
  function automatic coef_t reflect(coef_t fresh, coef_t old);
    return coef_t'((fresh <<< 1) - old);
  endfunction
endpackage

// File: rtl/hj_step.sv
module hj_step
  import hj_pkg::*;
#(
  parameter int FRAC = 24
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  logic  shrink,
  output coef_t step,
  output logic  last
);
  localparam coef_t STEP_INIT = coef_t'(((1 << FRAC) + 5) / 10);
  localparam coef_t STEP_MIN  = coef_t'(((1 << FRAC) + 500000) / 1000000);

  coef_t step_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      step_q <= '0;
    else if (load)   step_q <= STEP_INIT;
    else if (shrink) step_q <= step_q >>> 1;
  end

  assign step = step_q;
  assign last = (step_q >>> 1) < STEP_MIN;
endmodule

// File: rtl/hj_iter.sv
module hj_iter #(
  parameter int MAX_ITER = 1000,
  parameter int IW = $clog2(MAX_ITER + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [IW-1:0] cnt,
  output logic          last
);
  logic [IW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (inc) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt  = cnt_q;
  assign last = (cnt_q == IW'(MAX_ITER - 1));
endmodule

// File: rtl/hj_search.sv
module hj_search
  import hj_pkg::*;
#(
  parameter int NV = 6,
  parameter int FRAC = 24,
  parameter int MAX_ITER = 1000,
  localparam int IW = $clog2(MAX_ITER + 1),
  localparam int VW = NV * CW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [VW-1:0] init_coef,
  output logic          ev_req,
  output logic [VW-1:0] ev_coef,
  input  logic          ev_valid,
  input  logic [KW-1:0] ev_cost,
  output logic          done,
  output logic [VW-1:0] best_coef,
  output logic [KW-1:0] best_cost,
  output logic [IW-1:0] iter_count
);
  localparam int XW = (NV > 1) ? $clog2(NV) : 1;

  st_t          st;
  coef_t        base_q [NV];
  coef_t        cur_q  [NV];
  cost_t        base_cost_q;
  cost_t        cur_cost_q;
  logic [XW-1:0] idx_q;
  logic         pat_q;

  // named internal events
  coef_t step_w;
  logic  step_last_w;
  logic  iter_last_w;
  logic  take_w;
  logic  better_w;
  logic  accept_w;
  logic  shrink_w;
  logic  probing_w;

  assign take_w    = ev_req & ev_valid;
  assign better_w  = ev_cost < cur_cost_q;
  assign accept_w  = (st == S_END) && (cur_cost_q < base_cost_q);
  assign shrink_w  = (st == S_END) && !accept_w && !pat_q && !step_last_w;
  assign probing_w = (st == S_PLUS) || (st == S_MINUS);

  hj_step #(.FRAC(FRAC)) u_step (
    .clk(clk), .rst_n(rst_n), .load(start), .shrink(shrink_w && !start),
    .step(step_w), .last(step_last_w)
  );

  hj_iter #(.MAX_ITER(MAX_ITER), .IW(IW)) u_iter (
    .clk(clk), .rst_n(rst_n), .clr(start), .inc(accept_w && !start),
    .cnt(iter_count), .last(iter_last_w)
  );

  for (genvar g = 0; g < NV; g++) begin : g_lane
    assign ev_coef[g*CW +: CW] = (probing_w && idx_q == XW'(g))
                                 ? probe(cur_q[g], step_w, st == S_MINUS)
                                 : cur_q[g];
    assign best_coef[g*CW +: CW] = base_q[g];
  end

  assign ev_req    = (st == S_BASE) || probing_w || (st == S_PAT);
  assign done      = (st == S_FIN);
  assign best_cost = base_cost_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      base_cost_q <= '0;
      cur_cost_q  <= '0;
      idx_q       <= '0;
      pat_q       <= 1'b0;
      for (int i = 0; i < NV; i++) begin
        base_q[i] <= '0;
        cur_q[i]  <= '0;
      end
    end else if (start) begin
      st    <= S_BASE;
      idx_q <= '0;
      pat_q <= 1'b0;
      for (int i = 0; i < NV; i++) begin
        base_q[i] <= coef_t'(init_coef[i*CW +: CW]);
        cur_q[i]  <= coef_t'(init_coef[i*CW +: CW]);
      end
    end else begin
      case (st)
        S_BASE: if (take_w) begin
          base_cost_q <= ev_cost;
          cur_cost_q  <= ev_cost;
          idx_q       <= '0;
          st          <= S_PLUS;
        end
        S_PLUS, S_MINUS: if (take_w) begin
          if (better_w) begin
            cur_q[idx_q] <= probe(cur_q[idx_q], step_w, st == S_MINUS);
            cur_cost_q   <= ev_cost;
          end
          if (st == S_PLUS && !better_w) begin
            st <= S_MINUS;
          end else if (idx_q == XW'(NV - 1)) begin
            st <= S_END;
          end else begin
            idx_q <= idx_q + 1'b1;
            st    <= S_PLUS;
          end
        end
        S_END: begin
          idx_q <= '0;
          if (accept_w) begin
            for (int i = 0; i < NV; i++) begin
              base_q[i] <= cur_q[i];
              cur_q[i]  <= reflect(cur_q[i], base_q[i]);
            end
            base_cost_q <= cur_cost_q;
            st <= iter_last_w ? S_FIN : S_PAT;
          end else if (!pat_q && step_last_w) begin
            st <= S_FIN;
          end else begin
            for (int i = 0; i < NV; i++) cur_q[i] <= base_q[i];
            cur_cost_q <= base_cost_q;
            pat_q      <= 1'b0;
            st         <= S_PLUS;
          end
        end
        S_PAT: if (take_w) begin
          cur_cost_q <= ev_cost;
          pat_q      <= 1'b1;
          st         <= S_PLUS;
        end
        S_FIN:   st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hj_search_chk.sv
module hj_search_chk #(
  parameter int VW = 192,
  parameter int IW = 10,
  parameter int MAX_ITER = 1000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          ev_req,
  input logic          ev_valid,
  input logic [VW-1:0] ev_coef,
  input logic          done,
  input logic [31:0]   best_cost,
  input logic [IW-1:0] iter_count,
  input logic [31:0]   step,
  input logic          accept
);
  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_req && !ev_valid && !start |=> ev_req && $stable(ev_coef));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !ev_req);

  // R4
  cost_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !start |=> best_cost < $past(best_cost));

  // R6
  step_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $signed(step) <= $signed($past(step)));

  // R5
  iter_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (iter_count == $past(iter_count)) ||
               (iter_count == $past(iter_count) + 1'b1));

  // R7
  iter_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iter_count <= IW'(MAX_ITER));
endmodule

bind hj_search hj_search_chk #(.VW(VW), .IW(IW), .MAX_ITER(MAX_ITER)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .ev_req(ev_req),
  .ev_valid(ev_valid), .ev_coef(ev_coef), .done(done),
  .best_cost(best_cost), .iter_count(iter_count),
  .step(step_w), .accept(accept_w)
);

// File: tb/test_hj_search.sv
package test_hj_util;
  typedef logic signed [31:0] cv_t [6];

  function automatic logic [191:0] pack(cv_t v);
    logic [191:0] r;
    for (int i = 0; i < 6; i++) r[i*32 +: 32] = v[i];
    return r;
  endfunction

  // L1 distance to the target, saturated to 32 bits
  function automatic logic [31:0] l1_cost(logic [191:0] x, logic [191:0] t);
    longint s = 0;
    for (int i = 0; i < 6; i++) begin
      longint d = longint'($signed(x[i*32 +: 32])) - longint'($signed(t[i*32 +: 32]));
      if (d < 0) d = -d;
      s += d;
    end
    if (s > 64'hFFFF_FFFF) s = 64'hFFFF_FFFF;
    return s[31:0];
  endfunction
endpackage

module test_eval #(parameter int LAT = 2) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req,
  input  logic [191:0] coef,
  input  logic [191:0] target,
  output logic         valid,
  output logic [31:0]  cost
);
  logic [191:0] held;
  logic         busy;
  int           cnt;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0; cost <= '0; busy <= 1'b0; cnt <= 0; held <= '0;
    end else if (valid) begin
      valid <= 1'b0;
    end else if (busy) begin
      if (cnt <= 1) begin
        valid <= 1'b1;
        cost  <= test_hj_util::l1_cost(held, target);
        busy  <= 1'b0;
      end else cnt <= cnt - 1;
    end else if (req) begin
      held <= coef; busy <= 1'b1; cnt <= LAT;
    end
  end
endmodule

module test_hj_search;
  import test_hj_util::*;

  localparam int ONE = 16777216;
  localparam int STEP0 = 1677722;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic         start, ev_req, ev_valid, done;
  logic [191:0] init_coef, ev_coef, best_coef, target;
  logic [31:0]  ev_cost, best_cost;
  logic [9:0]   iter_count;

  logic         l_start, l_req, l_valid, l_done;
  logic [191:0] l_init, l_coef, l_best, l_target;
  logic [31:0]  l_cost, l_bcost;
  logic [1:0]   l_iter;

  hj_search i_hj_search (
    .clk(clk), .rst_n(rst_n), .start(start), .init_coef(init_coef),
    .ev_req(ev_req), .ev_coef(ev_coef), .ev_valid(ev_valid), .ev_cost(ev_cost),
    .done(done), .best_coef(best_coef), .best_cost(best_cost), .iter_count(iter_count)
  );
  test_eval u_ev (.clk(clk), .rst_n(rst_n), .req(ev_req), .coef(ev_coef),
    .target(target), .valid(ev_valid), .cost(ev_cost));

  hj_search #(.MAX_ITER(3)) i_lim (
    .clk(clk), .rst_n(rst_n), .start(l_start), .init_coef(l_init),
    .ev_req(l_req), .ev_coef(l_coef), .ev_valid(l_valid), .ev_cost(l_cost),
    .done(l_done), .best_coef(l_best), .best_cost(l_bcost), .iter_count(l_iter)
  );
  test_eval u_lev (.clk(clk), .rst_n(rst_n), .req(l_req), .coef(l_coef),
    .target(l_target), .valid(l_valid), .cost(l_cost));

  int checks = 0;
  int fails = 0;
  int n_eval = 0;
  logic [191:0] cand_log [4];

  // model outputs
  cv_t m_best;
  logic [31:0] m_cost;
  int m_it, m_nev;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (ev_valid) begin
      if (n_eval < 4) cand_log[n_eval] = ev_coef;
      n_eval++;
    end
  end

  // independent statement of the search procedure
  task automatic model(input cv_t x0, input logic [191:0] tgt, input int maxit);
    cv_t b, c, t, nx;
    logic [31:0] fb, fc, f;
    longint step;
    bit pat;
    b = x0; c = x0; step = STEP0; pat = 0;
    fb = l1_cost(pack(b), tgt); fc = fb;
    m_nev = 1; m_it = 0;
    forever begin
      for (int i = 0; i < 6; i++) begin
        t = c; t[i] = c[i] + 32'(step);
        f = l1_cost(pack(t), tgt); m_nev++;
        if (f < fc) begin c = t; fc = f; end
        else begin
          t[i] = c[i] - 32'(step);
          f = l1_cost(pack(t), tgt); m_nev++;
          if (f < fc) begin c = t; fc = f; end
        end
      end
      if (fc < fb) begin
        m_it++;
        for (int i = 0; i < 6; i++) nx[i] = c[i] + c[i] - b[i];
        b = c; fb = fc;
        if (m_it == maxit) break;
        c = nx; fc = l1_cost(pack(c), tgt); m_nev++; pat = 1;
      end else if (pat) begin
        c = b; fc = fb; pat = 0;
      end else begin
        if (step / 2 < 17) break;
        step = step / 2; c = b; fc = fb;
      end
    end
    m_best = b; m_cost = fb;
  endtask

  task automatic run_main(input cv_t x0, input cv_t tg, output bit ok);
    int w = 0;
    target = pack(tg);
    n_eval = 0;
    @(negedge clk);
    init_coef = pack(x0); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && w < 60000) begin @(negedge clk); w++; end
    ok = done;
    if (!ok) chk(0, "R8 watchdog", w, 0);
  endtask

  task automatic cmp_result(input string tag, input cv_t x0, input cv_t tg);
    model(x0, pack(tg), 1000);
    for (int i = 0; i < 6; i++)
      chk($signed(best_coef[i*32 +: 32]) == m_best[i], tag,
          $signed(best_coef[i*32 +: 32]), m_best[i]);
    chk(best_cost == m_cost, tag, best_cost, m_cost);
    chk(int'(iter_count) == m_it, tag, iter_count, m_it);
    chk(n_eval == m_nev, tag, n_eval, m_nev);
  endtask

  task automatic t_reset;
    chk(done == 1'b0, "R8 reset done", done, 0);
    chk(ev_req == 1'b0, "R8 reset req", ev_req, 0);
    chk(iter_count == 0, "R1 reset iter", iter_count, 0);
  endtask

  task automatic t_order;
    cv_t x0, tg;
    bit ok;
    logic [191:0] held;
    foreach (x0[i]) begin x0[i] = 0; tg[i] = 0; end
    tg[0] = -ONE;
    run_main(x0, tg, ok);
    if (!ok) return;
    chk(cand_log[0] == pack(x0), "R1 first candidate", $signed(cand_log[0][31:0]), 0);
    chk($signed(cand_log[1][31:0]) == STEP0, "R3 plus probe first",
        $signed(cand_log[1][31:0]), STEP0);
    chk($signed(cand_log[2][31:0]) == -STEP0, "R3 minus probe second",
        $signed(cand_log[2][31:0]), -STEP0);
    chk($signed(cand_log[3][31:0]) == -STEP0 && $signed(cand_log[3][63:32]) == STEP0,
        "R3 next coordinate keeps improvement", $signed(cand_log[3][63:32]), STEP0);
    cmp_result("R4 R5 R10 order run", x0, tg);
    // R8: pulse and hold
    held = best_coef;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(done == 1'b0, "R8 done one cycle", done, 0);
      chk(ev_req == 1'b0, "R8 quiet after done", ev_req, 0);
      chk(best_coef == held, "R8 best held", $signed(best_coef[31:0]), $signed(held[31:0]));
    end
  endtask

  task automatic t_mixed;
    cv_t x0, tg;
    bit ok;
    logic [191:0] b1;
    logic [31:0] c1;
    int i1;
    foreach (x0[i]) x0[i] = 0;
    tg[0] = 5872026; tg[1] = -12079596; tg[2] = 18454938;
    tg[3] = 0; tg[4] = -838861; tg[5] = 8388608;
    run_main(x0, tg, ok);
    if (!ok) return;
    cmp_result("R4 R5 R10 mixed target", x0, tg);
    b1 = best_coef; c1 = best_cost; i1 = int'(iter_count);
    run_main(x0, tg, ok);
    if (!ok) return;
    chk(best_coef == b1, "R9 repeat vector", $signed(best_coef[31:0]), $signed(b1[31:0]));
    chk(best_cost == c1, "R9 repeat cost", best_cost, c1);
    chk(int'(iter_count) == i1, "R9 repeat iter", iter_count, i1);
  endtask

  task automatic t_at_target;
    cv_t x0;
    bit ok;
    int s, rounds, exp_ev;
    x0[0] = 3 * ONE / 4; x0[1] = -ONE; x0[2] = 12345; x0[3] = 0;
    x0[4] = ONE / 3; x0[5] = -7;
    run_main(x0, x0, ok);
    if (!ok) return;
    // R6: count step values from 0.1 down while halving stays >= 17
    s = STEP0; rounds = 1;
    while ((s >> 1) >= 17) begin s = s >> 1; rounds++; end
    exp_ev = 1 + 12 * rounds;
    chk(n_eval == exp_ev, "R6 evaluations until step floor", n_eval, exp_ev);
    chk(iter_count == 0, "R6 no pattern move", iter_count, 0);
    chk(best_coef == pack(x0), "R6 start kept", $signed(best_coef[31:0]), x0[0]);
    chk(best_cost == 0, "R6 zero cost", best_cost, 0);
  endtask

  task automatic t_limit;
    cv_t x0, tg;
    int w = 0;
    foreach (x0[i]) begin x0[i] = 0; tg[i] = 3 * ONE; end
    l_target = pack(tg);
    @(negedge clk);
    l_init = pack(x0); l_start = 1'b1;
    @(negedge clk);
    l_start = 1'b0;
    while (!l_done && w < 60000) begin @(negedge clk); w++; end
    if (!l_done) begin chk(0, "R7 watchdog", w, 0); return; end
    model(x0, pack(tg), 3);
    chk(l_iter == 2'd3, "R7 stops at limit", l_iter, 3);
    chk(m_it == 3, "R7 model reaches limit", m_it, 3);
    for (int i = 0; i < 6; i++)
      chk($signed(l_best[i*32 +: 32]) == m_best[i], "R7 best at limit",
          $signed(l_best[i*32 +: 32]), m_best[i]);
    chk(l_bcost == m_cost, "R7 cost at limit", l_bcost, m_cost);
  endtask

  initial begin
    start = 0; init_coef = '0; target = '0;
    l_start = 0; l_init = '0; l_target = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_order();
    t_mixed();
    t_at_target();
    t_limit();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule